// File: doc/BRIEF.md
# Raster-to-Tile Stream Feeder

This block sits between a two-bank frame store and an 8x8 block transform engine. The capture side writes one bank in raster order while the other bank holds the previous frame. The capture side flips a single bank-select level each time it finishes a frame. The feeder watches that level while idle. When the level changes, it reads the complete frame from the bank the writer has just left. No request and no acknowledge pass between the two sides.

The feeder converts raster order into tile order using address generation alone. Inside a tile it walks the eight columns of a line, then moves to the next of the eight lines. Tiles go left to right across a tile-row, and tile-rows go top to bottom. The read address is the concatenation {bank, line, column}. The memory answers one clock after the address, so the pixel and its qualifiers are aligned to the returned data. A strobe marks the first pixel of every 64-pixel tile. Tiles follow one another with no idle cycle. A flip that arrives while a frame is being read is held and served as soon as that frame ends. The default frame is 256 pixels wide and 240 lines high, which gives 32 by 30 tiles.

Top module: `tile_stream_feeder`

## Requirements
- R1: While reset is held, and afterwards until the first change of `bank_sel`, `rd_en`, `pix_valid` and `sob` are all low.
- R2: A change of `bank_sel` starts one frame read from the bank equal to the value `bank_sel` held before the change. That bank is the most significant bit of `rd_addr` and is constant for the whole frame.
- R3: `rd_addr` is {bank, line, column}, with line = tile_row*8 + y and column = tile_col*8 + x. The column field is the least significant `$clog2(FRAME_W)` bits. x advances fastest, then y, then tile_col, then tile_row. Every frame starts at line 0, column 0.
- R4: `pix_valid` is high exactly one cycle after each cycle with `rd_en` high. `pixel` equals the memory data returned for that read.
- R5: `sob` is high only together with `pix_valid`, and only on the pixel read from x = 0, y = 0 of a tile.
- R6: A frame of FRAME_W*FRAME_H pixels is delivered as one unbroken run of `pix_valid`, with no gap between consecutive tiles.
- R7: A change of `bank_sel` during a frame read is remembered. This includes a change during the frame's last read cycle. `pix_valid` is then low for exactly one cycle before the next frame begins.
- R8: After the last pixel of the last tile, the block stops reading and waits for the next change of `bank_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | Bank currently written by the capture side; a change means a frame is complete |
| rd_data | input | PIX_W | Memory read data, valid one cycle after the address |
| rd_addr | output | 1+$clog2(FRAME_H)+$clog2(FRAME_W) | Read address {bank, line, column} |
| rd_en | output | 1 | Read enable |
| pixel | output | PIX_W | Pixel to the transform engine |
| pix_valid | output | 1 | Pixel qualifier, aligned to returned data |
| sob | output | 1 | First pixel of a 64-pixel tile |

## Verification
Two functions can fall in the same cycle. One is the detection of a new `bank_sel` flip. The other is the end of the frame currently being read, where the state machine returns to waiting. The bench provokes this in two ways. In one case it flips the select in the middle of a frame. In the other it flips the select on exactly the cycle that carries the last read address of a frame. In both cases it judges the result in three ways. The scoreboard must see the pending frame from the correct bank. The gap in `pix_valid` must be exactly one cycle. No frame may be lost or duplicated.

// File: rtl/feeder_pkg.sv
package feeder_pkg;

    typedef enum logic {
        FS_WAIT = 1'b0,
        FS_LOAD = 1'b1
    } feed_state_e;

    // Counter width for a count of n items; at least one bit.
    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bank_toggle_watch.sv
// Detects a flip of the writer's bank-select level and holds it until consumed.
module bank_toggle_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic bank_sel,
    input  logic consume,
    output logic pend,
    output logic pend_bank
);

    typedef struct packed {
        logic last;   // level seen on the previous clock
        logic pend;   // a finished frame waits to be read
        logic bank;   // bank the writer left at the latest flip
    } watch_t;

    watch_t w_d, w_q;

    always_comb begin
        w_d      = w_q;
        w_d.last = bank_sel;
        if (bank_sel != w_q.last) begin
            // a new flip wins over a consume in the same cycle
            w_d.pend = 1'b1;
            w_d.bank = w_q.last;
        end else if (consume) begin
            w_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign pend      = w_q.pend;
    assign pend_bank = w_q.bank;

endmodule

// File: rtl/tile_walk.sv
// Nested counters: column in tile, line in tile, tile column, tile row.
module tile_walk #(
    parameter int unsigned TILE    = 8,
    parameter int unsigned TILES_X = 32,
    parameter int unsigned TILES_Y = 30,
    localparam int unsigned TB     = $clog2(TILE),
    localparam int unsigned TC_W   = feeder_pkg::width_of(TILES_X),
    localparam int unsigned TR_W   = feeder_pkg::width_of(TILES_Y)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [TB-1:0]   x,
    output logic [TB-1:0]   y,
    output logic [TC_W-1:0] tc,
    output logic [TR_W-1:0] tr,
    output logic            tile_first,
    output logic            frame_last
);

    localparam logic [TB-1:0]   X_MAX  = TB'(TILE - 1);
    localparam logic [TC_W-1:0] TC_MAX = TC_W'(TILES_X - 1);
    localparam logic [TR_W-1:0] TR_MAX = TR_W'(TILES_Y - 1);

    typedef struct packed {
        logic [TB-1:0]   x;
        logic [TB-1:0]   y;
        logic [TC_W-1:0] tc;
        logic [TR_W-1:0] tr;
    } walk_t;

    walk_t c_d, c_q;

    logic x_wrap, y_wrap, tc_wrap, tr_wrap;

    always_comb begin
        x_wrap  = (c_q.x  == X_MAX);
        y_wrap  = (c_q.y  == X_MAX);
        tc_wrap = (c_q.tc == TC_MAX);
        tr_wrap = (c_q.tr == TR_MAX);

        c_d = c_q;
        if (step) begin
            if (!x_wrap) begin
                c_d.x = c_q.x + 1'b1;
            end else begin
                c_d.x = '0;
                if (!y_wrap) begin
                    c_d.y = c_q.y + 1'b1;
                end else begin
                    c_d.y = '0;
                    if (!tc_wrap) begin
                        c_d.tc = c_q.tc + 1'b1;
                    end else begin
                        c_d.tc = '0;
                        c_d.tr = tr_wrap ? '0 : c_q.tr + 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign x          = c_q.x;
    assign y          = c_q.y;
    assign tc         = c_q.tc;
    assign tr         = c_q.tr;
    assign tile_first = (c_q.x == '0) && (c_q.y == '0);
    assign frame_last = x_wrap && y_wrap && tc_wrap && tr_wrap;

endmodule

// File: rtl/feed_ctrl.sv
// Wait / load sequencer; latches the bank to read when a frame is taken.
module feed_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pend,
    input  logic pend_bank,
    input  logic frame_last,
    output logic consume,
    output logic loading,
    output logic bank
);

    import feeder_pkg::*;

    typedef struct packed {
        feed_state_e st;
        logic        bank;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        consume = 1'b0;
        unique case (s_q.st)
            FS_WAIT: begin
                if (pend) begin
                    s_d.st   = FS_LOAD;
                    s_d.bank = pend_bank;
                    consume  = 1'b1;
                end
            end
            FS_LOAD: begin
                if (frame_last) begin
                    s_d.st = FS_WAIT;
                end
            end
            default: s_d.st = FS_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: FS_WAIT, bank: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign loading = (s_q.st == FS_LOAD);
    assign bank    = s_q.bank;

endmodule

// File: rtl/feed_align.sv
// Delays read qualifiers by the memory latency so they meet the returned data.
module feed_align (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic tile_first,
    output logic pix_valid,
    output logic sob
);

    typedef struct packed {
        logic vld;
        logic sob;
    } align_t;

    align_t a_d, a_q;

    always_comb begin
        a_d.vld = rd_en;
        a_d.sob = rd_en && tile_first;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
        end else begin
            a_q <= a_d;
        end
    end

    assign pix_valid = a_q.vld;
    assign sob       = a_q.sob;

endmodule

// File: rtl/tile_stream_feeder.sv
// Reads a finished raster frame from a two-bank store as a stream of 8x8 tiles.
module tile_stream_feeder #(
    parameter int unsigned FRAME_W  = 256,
    parameter int unsigned FRAME_H  = 240,
    parameter int unsigned TILE     = 8,
    parameter int unsigned PIX_W    = 8,
    localparam int unsigned TB      = $clog2(TILE),
    localparam int unsigned TILES_X = FRAME_W / TILE,
    localparam int unsigned TILES_Y = FRAME_H / TILE,
    localparam int unsigned TC_W    = feeder_pkg::width_of(TILES_X),
    localparam int unsigned TR_W    = feeder_pkg::width_of(TILES_Y),
    localparam int unsigned COL_W   = TC_W + TB,
    localparam int unsigned ROW_W   = TR_W + TB,
    localparam int unsigned ADDR_W  = 1 + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_sel,
    input  logic [PIX_W-1:0]  rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_en,
    output logic [PIX_W-1:0]  pixel,
    output logic              pix_valid,
    output logic              sob
);

    logic            pend, pend_bank, consume, loading, bank;
    logic            tile_first, frame_last;
    logic [TB-1:0]   x, y;
    logic [TC_W-1:0] tc;
    logic [TR_W-1:0] tr;

    bank_toggle_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_sel  (bank_sel),
        .consume   (consume),
        .pend      (pend),
        .pend_bank (pend_bank)
    );

    feed_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .pend_bank  (pend_bank),
        .frame_last (frame_last),
        .consume    (consume),
        .loading    (loading),
        .bank       (bank)
    );

    tile_walk #(
        .TILE    (TILE),
        .TILES_X (TILES_X),
        .TILES_Y (TILES_Y)
    ) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (loading),
        .x          (x),
        .y          (y),
        .tc         (tc),
        .tr         (tr),
        .tile_first (tile_first),
        .frame_last (frame_last)
    );

    feed_align u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (loading),
        .tile_first (tile_first),
        .pix_valid  (pix_valid),
        .sob        (sob)
    );

    // line = {tile row, y}, column = {tile column, x}
    assign rd_addr = {bank, tr, y, tc, x};
    assign rd_en   = loading;
    assign pixel   = rd_data;

endmodule

// File: rtl/feeder_chk.sv
module feeder_chk #(
    parameter int unsigned ADDR_W = 17,
    parameter int unsigned TB     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              pix_valid,
    input logic              sob
);

    // R4
    valid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> pix_valid);

    // R4
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !pix_valid);

    // R5
    sob_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sob |-> pix_valid);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_addr[TB-1:0] != '0)) |->
            ($past(rd_en) && (rd_addr == $past(rd_addr) + 1'b1)));

    // R2
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_addr[ADDR_W-1] == $past(rd_addr[ADDR_W-1])));

    // R3
    frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (rd_addr[ADDR_W-2:0] == '0));

    // R6
    block_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !sob) |-> $past(pix_valid));

endmodule

bind tile_stream_feeder feeder_chk #(
    .ADDR_W (ADDR_W),
    .TB     (TB)
) u_feeder_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .pix_valid (pix_valid),
    .sob       (sob)
);

// File: tb/tb_tile_stream_feeder.sv
module tb_tile_stream_feeder;

    localparam int CLK_PERIOD = 10;
    localparam int W      = 32;
    localparam int H      = 24;
    localparam int T      = 8;
    localparam int COL_W  = $clog2(W);
    localparam int ROW_W  = $clog2(H);
    localparam int ADDR_W = 1 + ROW_W + COL_W;
    localparam int NPIX   = W * H;
    localparam int WD_CYC = 50000;
    localparam logic [ADDR_W-2:0] LAST_LOW = (ADDR_W-1)'(((H - 1) << COL_W) | (W - 1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bank_sel = 1'b0;
    logic [7:0]        rd_data = '0;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_en;
    logic [7:0]        pixel;
    logic              pix_valid;
    logic              sob;

    int checks = 0;
    int errors = 0;
    int frames_started = 0;
    int last_gap = 0;
    int gap = 1000;
    int run = 0;
    logic prev_valid = 1'b0;
    bit done = 1'b0;

    logic [ADDR_W-1:0] exp_addr[$];
    logic [8:0]        exp_pix[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    tile_stream_feeder #(
        .FRAME_W (W),
        .FRAME_H (H),
        .TILE    (T),
        .PIX_W   (8)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bank_sel  (bank_sel),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .rd_en     (rd_en),
        .pixel     (pixel),
        .pix_valid (pix_valid),
        .sob       (sob)
    );

    function automatic logic [7:0] mem_f(input logic [ADDR_W-1:0] a);
        int v;
        v = int'(a);
        return 8'((v * 73) ^ (v >> 4) ^ 8'h5A);
    endfunction

    // memory model with one clock of read latency
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem_f(rd_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // driver: flip the select and push the frame expected from the left bank
    task automatic kick();
        logic old;
        old = bank_sel;
        bank_sel = ~bank_sel;
        for (int tr = 0; tr < H / T; tr++)
            for (int tc = 0; tc < W / T; tc++)
                for (int y = 0; y < T; y++)
                    for (int x = 0; x < T; x++) begin
                        logic [ADDR_W-1:0] a;
                        a = {old, ROW_W'(tr * T + y), COL_W'(tc * T + x)};
                        exp_addr.push_back(a);
                        exp_pix.push_back({(x == 0) && (y == 0), mem_f(a)});
                    end
    endtask

    // monitor, sampling away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_en) begin
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R8", "read with no frame pending", int'(rd_addr), 0);
                end else begin
                    logic [ADDR_W-1:0] ea;
                    ea = exp_addr.pop_front();
                    check(rd_addr == ea, "R3", "read address", int'(rd_addr), int'(ea));
                end
            end
            if (pix_valid) begin
                if (exp_pix.size() == 0) begin
                    check(1'b0, "R4", "unexpected pixel", int'(pixel), 0);
                end else begin
                    logic [8:0] ep;
                    ep = exp_pix.pop_front();
                    check(pixel == ep[7:0], "R4", "pixel value", int'(pixel), int'(ep[7:0]));
                    check(sob == ep[8], "R5", "tile start strobe", int'(sob), int'(ep[8]));
                end
                run++;
            end else if (sob) begin
                check(1'b0, "R5", "strobe without valid", 1, 0);
            end
            if (pix_valid && !prev_valid) begin
                frames_started++;
                last_gap = gap;
            end
            if (!pix_valid && prev_valid) begin
                check(run == NPIX, "R6", "unbroken frame run", run, NPIX);
                run = 0;
            end
            gap = pix_valid ? 0 : gap + 1;
            prev_valid = pix_valid;
        end
    end

    task automatic wait_drained();
        while (exp_pix.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired at %0d cycles", WD_CYC);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet while reset is held
        check(rd_en == 1'b0, "R1", "rd_en in reset", int'(rd_en), 0);
        check(pix_valid == 1'b0, "R1", "pix_valid in reset", int'(pix_valid), 0);
        check(sob == 1'b0, "R1", "sob in reset", int'(sob), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R1: nothing read before the first flip
        check(frames_started == 0, "R1", "frames before any flip", frames_started, 0);
        check(rd_en == 1'b0, "R1", "rd_en idle after reset", int'(rd_en), 0);

        // R2: first flip 0->1, frame from bank 0
        kick();
        wait_drained();
        check(frames_started == 1, "R2", "frames after first flip", frames_started, 1);

        // R8: back to waiting, no more reads
        repeat (30) @(negedge clk);
        check(frames_started == 1, "R8", "frames while idle", frames_started, 1);
        check(rd_en == 1'b0, "R8", "rd_en while idle", int'(rd_en), 0);

        // R7: flip in the middle of a frame is held and served
        kick();
        repeat (100) @(negedge clk);
        kick();
        while (frames_started < 3) @(negedge clk);
        check(last_gap == 1, "R7", "gap before pending frame", last_gap, 1);
        wait_drained();
        check(frames_started == 3, "R7", "frames after mid-frame flip", frames_started, 3);

        // R7: flip landing on the last read cycle of a frame
        kick();
        while (!(rd_en && rd_addr[ADDR_W-2:0] == LAST_LOW)) @(negedge clk);
        kick();
        while (frames_started < 5) @(negedge clk);
        check(last_gap == 1, "R7", "gap after flip on last read", last_gap, 1);
        wait_drained();
        check(frames_started == 5, "R7", "frames after last-cycle flip", frames_started, 5);

        repeat (20) @(negedge clk);
        check(frames_started == 5, "R8", "no extra frame", frames_started, 5);
        check(exp_addr.size() == 0, "R3", "addresses left over", exp_addr.size(), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule